// File: doc/BRIEF.md
# Inter-Processor Mailbox Channel

This block carries 32-bit messages in one direction between two processors. It sits on a simple word-addressed slave bus with read and write strobes. The producing processor writes each message into a small first-in first-out queue. The consuming processor polls a status word and then reads each message in arrival order. Each read of the data word removes the message it returns. Because of that, two processors can run a closed-loop request and acknowledge exchange with no interrupts: one mailbox for each direction, and each side polling its own status word.

The status word has four fields. One flag says the queue has drained, so the sender knows it may post a new message. A second flag says at least one message is waiting, so the receiver knows it may read. A sticky flag records that a write arrived while the queue was full and was discarded. All other status bits read as zero. The block gives no meaning to the message contents.

Top module: `mbox_channel`

## Requirements
- R1: A synchronous active-high reset empties the queue, clears the overflow flag and sets rdata to zero. A status read after reset returns 0x1.
- R2: A write to word address 0 (byte offset 0x0) appends wdata to the queue. Reads of word address 0 return the stored messages oldest first, and order holds across pointer wrap-around.
- R3: Status (word address 2, byte offset 0x8) bit 0 reads 1 exactly when the queue holds no message.
- R4: Status bit 1 reads 1 exactly when the queue holds at least one message.
- R5: A read strobe on word address 0 removes the message in the same clock cycle. rdata shows the result one cycle after the strobe and keeps that value until the next read strobe.
- R6: The queue depth is a parameter, 4 words by default. A write to word address 0 while the queue is full is discarded and leaves the stored messages unchanged.
- R7: A discarded write sets status bit 2. The bit stays set until a write to word address 2 with wdata bit 2 equal to 1 clears it.
- R8: A read of word address 0 while the queue is empty returns zero and leaves the queue unchanged.
- R9: Status bits 31 to 3 read as zero. A write to word address 2 changes nothing except the clear of bit 2. Writes to word addresses 1 and 3 are ignored, and reads of those addresses return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| rd_en | input | 1 | Read strobe for the addressed word |
| wr_en | input | 1 | Write strobe for the addressed word |
| addr | input | ADDR_W (2) | Word address: 0 = message data, 2 = status |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Registered read data, valid the cycle after rd_en |

## Verification
The failures that matter come from a queue occupancy count that drifts away from the real contents. Such a drift shows at the ports on the next status read, because the empty and waiting flags no longer match the number of writes minus reads. It also shows on the next data read, as a repeated, skipped or stale message. A head pointer that wraps wrongly appears only after more messages have passed through than the queue depth, so the bench streams several rounds of messages through the queue. The overflow flag is checked both right after a discarded write and after the queue has drained, so that a flag which fails to stick shows up within one status read.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  // Word addresses that software relies on.
  localparam int unsigned DATA_WORD   = 0;
  localparam int unsigned STATUS_WORD = 2;

  // Status bit positions.
  localparam int unsigned ST_EMPTY = 0;
  localparam int unsigned ST_AVAIL = 1;
  localparam int unsigned ST_OVF   = 2;

  typedef enum logic [1:0] {
    SEL_DATA,
    SEL_STATUS,
    SEL_NONE
  } reg_sel_e;

  // Status word image; every bit above the overflow flag is zero.
  function automatic logic [31:0] pack_status(input logic q_empty, input logic ovf);
    logic [31:0] s;
    s           = '0;
    s[ST_EMPTY] = q_empty;
    s[ST_AVAIL] = ~q_empty;
    s[ST_OVF]   = ovf;
    return s;
  endfunction

  // Occupancy after one cycle of accepted pushes and pops.
  function automatic int unsigned level_after(input int unsigned cur,
                                              input logic push, input logic pop);
    int unsigned n;
    n = cur;
    if (push && !pop) n = cur + 1;
    if (pop && !push) n = cur - 1;
    return n;
  endfunction

endpackage

// File: rtl/mbox_queue.sv
module mbox_queue #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 4,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_req,
  input  logic              pop_req,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] head,
  output logic              push_ok,
  output logic              pop_ok,
  output logic              q_empty,
  output logic              q_full,
  output logic [CNT_W-1:0]  level
);
  import mbox_pkg::*;

  logic [DATA_W-1:0] slots [DEPTH];
  logic [PTR_W-1:0]  wr_ptr;
  logic [PTR_W-1:0]  rd_ptr;

  function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
    if (p == PTR_W'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  assign q_empty = (level == '0);
  assign q_full  = (level == CNT_W'(DEPTH));
  assign pop_ok  = pop_req & ~q_empty;
  assign push_ok = push_req & (~q_full | pop_ok);
  assign head    = slots[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) slots[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push_ok) wr_ptr <= ptr_step(wr_ptr);
      if (pop_ok)  rd_ptr <= ptr_step(rd_ptr);
      level <= CNT_W'(level_after(int'(level), push_ok, pop_ok));
    end
  end

endmodule

// File: rtl/mbox_regs.sv
module mbox_regs #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] head,
  input  logic              q_empty,
  input  logic              push_ok,
  output logic              push_req,
  output logic              pop_req,
  output logic              drop,
  output logic              ovf,
  output logic [DATA_W-1:0] rdata
);
  import mbox_pkg::*;

  reg_sel_e    sel;
  logic        ovf_clr;
  logic [31:0] status_img;

  always_comb begin
    if (addr == ADDR_W'(DATA_WORD))        sel = SEL_DATA;
    else if (addr == ADDR_W'(STATUS_WORD)) sel = SEL_STATUS;
    else                                   sel = SEL_NONE;
  end

  assign push_req   = wr_en & (sel == SEL_DATA);
  assign pop_req    = rd_en & (sel == SEL_DATA);
  assign drop       = push_req & ~push_ok;
  assign ovf_clr    = wr_en & (sel == SEL_STATUS) & wdata[ST_OVF];
  assign status_img = pack_status(q_empty, ovf);

  always_ff @(posedge clk) begin
    if (rst)          ovf <= 1'b0;
    else if (drop)    ovf <= 1'b1;
    else if (ovf_clr) ovf <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      case (sel)
        SEL_DATA:   rdata <= q_empty ? '0 : head;
        SEL_STATUS: rdata <= DATA_W'(status_img);
        default:    rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/mbox_channel.sv
module mbox_channel #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DEPTH  = 4,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  // Internal events brought out as named wires for the checker.
  logic              push_req;
  logic              pop_req;
  logic              push_ok;
  logic              pop_ok;
  logic              drop;
  logic              ovf;
  logic              q_empty;
  logic              q_full;
  logic [CNT_W-1:0]  q_level;
  logic [DATA_W-1:0] q_head;

  mbox_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .head     (q_head),
    .q_empty  (q_empty),
    .push_ok  (push_ok),
    .push_req (push_req),
    .pop_req  (pop_req),
    .drop     (drop),
    .ovf      (ovf),
    .rdata    (rdata)
  );

  mbox_queue #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_queue (
    .clk      (clk),
    .rst      (rst),
    .push_req (push_req),
    .pop_req  (pop_req),
    .din      (wdata),
    .head     (q_head),
    .push_ok  (push_ok),
    .pop_ok   (pop_ok),
    .q_empty  (q_empty),
    .q_full   (q_full),
    .level    (q_level)
  );

endmodule

// File: rtl/mbox_channel_chk.sv
module mbox_channel_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DEPTH  = 4,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_en,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic [CNT_W-1:0]  level,
  input logic              push_ok,
  input logic              pop_ok,
  input logic              drop,
  input logic              ovf
);

  // R1
  reset_empty_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (level == '0 && !ovf));

  // R3
  empty_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == ADDR_W'(2)) |=> (rdata[0] == ($past(level) == '0)));

  // R4
  avail_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == ADDR_W'(2)) |=> (rdata[1] == ($past(level) != '0)));

  // R5
  pop_shrinks_chk: assert property (@(posedge clk) disable iff (rst)
    (pop_ok && !push_ok) |=> (level == $past(level) - 1'b1));

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (level <= CNT_W'(DEPTH)));

  // R6
  full_drop_chk: assert property (@(posedge clk) disable iff (rst)
    drop |=> $stable(level));

  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf && !(wr_en && addr == ADDR_W'(2) && wdata[2])) |=> ovf);

  // R8
  empty_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en && addr == '0 && level == '0) |=> (rdata == '0 && level == '0));

  // R9
  status_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == ADDR_W'(2)) |=> (rdata[DATA_W-1:3] == '0));

endmodule

bind mbox_channel mbox_channel_chk #(
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W),
  .DEPTH  (DEPTH)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .rd_en   (rd_en),
  .wr_en   (wr_en),
  .addr    (addr),
  .wdata   (wdata),
  .rdata   (rdata),
  .level   (q_level),
  .push_ok (push_ok),
  .pop_ok  (pop_ok),
  .drop    (drop),
  .ovf     (ovf)
);

// File: tb/mbox_channel_bench.sv
module mbox_channel_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 4;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  logic [31:0] model[$];
  bit m_ovf = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbox_channel u_mbox_channel (
    .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a == 2'd0) begin
      if (model.size() < DEPTH) model.push_back(d);
      else m_ovf = 1;
    end else if (a == 2'd2 && d[2]) begin
      m_ovf = 0;
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
    if (a == 2'd0 && model.size() > 0) void'(model.pop_front());
  endtask

  function automatic logic [31:0] exp_status();
    logic [31:0] s = '0;
    s[0] = (model.size() == 0);
    s[1] = (model.size() != 0);
    s[2] = m_ovf;
    return s;
  endfunction

  task automatic chk_status(input string tag);
    logic [31:0] e;
    logic [31:0] v;
    e = exp_status();
    rd(2'd2, v);
    chk(tag, v, e);
  endtask

  task automatic chk_pop(input string tag);
    logic [31:0] e;
    logic [31:0] v;
    e = (model.size() > 0) ? model[0] : 32'h0;
    rd(2'd0, v);
    chk(tag, v, e);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model.delete(); m_ovf = 0;
    chk("R1 rdata after reset", rdata, 32'h0);
    chk_status("R1 status after reset");
  endtask

  task automatic t_order();
    wr(2'd0, 32'hA000_0001);
    wr(2'd0, 32'hA000_0002);
    wr(2'd0, 32'hA000_0003);
    chk_status("R4 waiting flag with 3 messages");
    for (int i = 0; i < 3; i++) chk_pop("R2 oldest-first read");
    chk_status("R3 empty flag after draining");
  endtask

  task automatic t_full();
    for (int i = 0; i < DEPTH; i++) wr(2'd0, 32'hB000_0000 + i);
    chk_status("R6 status when full");
    wr(2'd0, 32'hDEAD_BEEF);
    chk_status("R7 overflow flag after discarded write");
    for (int i = 0; i < DEPTH; i++) chk_pop("R6 contents kept after discard");
    chk_status("R7 overflow flag sticks after drain");
  endtask

  task automatic t_clear();
    wr(2'd2, 32'hFFFF_FFFB);
    chk_status("R9 status write without bit 2 ignored");
    wr(2'd2, 32'h0000_0004);
    chk_status("R7 write 1 to bit 2 clears overflow");
  endtask

  task automatic t_empty_read();
    chk_pop("R8 empty read returns zero");
    chk_status("R8 empty read leaves queue empty");
    wr(2'd0, 32'hC0DE_0001);
    chk_pop("R8 queue intact after empty read");
  endtask

  task automatic t_unused();
    logic [31:0] v;
    wr(2'd1, 32'h1111_1111);
    wr(2'd3, 32'h3333_3333);
    chk_status("R9 writes to unused words do not push");
    rd(2'd1, v); chk("R9 unused word 1 reads zero", v, 32'h0);
    rd(2'd3, v); chk("R9 unused word 3 reads zero", v, 32'h0);
  endtask

  task automatic t_timing();
    logic [31:0] v;
    wr(2'd0, 32'h5555_0001);
    wr(2'd0, 32'h5555_0002);
    rd(2'd0, v); chk("R5 first message", v, 32'h5555_0001);
    repeat (3) @(negedge clk);
    chk("R5 rdata holds when idle", rdata, 32'h5555_0001);
    rd_en = 1'b1; addr = 2'd0;
    #1;
    chk("R5 rdata unchanged during strobe cycle", rdata, 32'h5555_0001);
    @(negedge clk);
    rd_en = 1'b0;
    chk("R5 rdata one cycle after strobe", rdata, 32'h5555_0002);
    void'(model.pop_front());
    chk_status("R5 pop took effect on strobe cycle");
  endtask

  task automatic t_wrap();
    for (int r = 0; r < 6; r++) begin
      for (int k = 0; k < 3; k++) wr(2'd0, 32'hE000_0000 + r * 16 + k);
      for (int k = 0; k < 3; k++) chk_pop("R2 order across wrap");
    end
    chk_status("R3 empty after wrap rounds");
  endtask

  initial begin
    t_reset();
    t_order();
    t_full();
    t_clear();
    t_empty_read();
    t_unused();
    t_timing();
    t_wrap();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule